// File: doc/BRIEF.md
# SCL Current-Source Pull-Up Controller

This block sits on the master side of a two-wire serial bus that supports a high-speed transfer mode. In that mode the master speeds up the last part of each SCL rising edge with a current-source pull-up. The block produces the single enable for that pull-up. It watches four things: the SCL line level after synchronisation, whether the master itself is pulling SCL low, the sequencer's strobes, and the high-speed mode flag.

The pull-up is never switched on at a fixed time. It turns on only once SCL is seen high, which means every device on the bus has released the line. High-speed mode begins after the master code and its not-acknowledge. From then on the enable is withdrawn after each repeated START and after each acknowledge slot. This lets a slave hold SCL low until its data is ready. The enable comes back after SCL has first been observed low and then observed high again. A STOP, or leaving high-speed mode, turns the pull-up off for good. Only the resistor pull-up remains until the next high-speed entry.

Top module: `scl_cs_pullup_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, pu_en_o is 0. A pending re-enable is cleared by reset. If hs_mode_i is already high at reset release, the pull-up stays off until hs_mode_i goes low and then rises again.
- R2: A rising edge of hs_mode_i arms the first enable. pu_en_o becomes 1 at the first clock edge at which the synchronised SCL is high and scl_drive_low_i is 0. When SCL is steadily high, this is the second rising clock edge after the one that samples the new hs_mode_i.
- R3: scl_i passes through a 2-flop synchroniser. pu_en_o can rise no earlier than the third rising edge after scl_i is first sampled high.
- R4: A rep_start_i pulse sampled while hs_mode_i is 1 forces pu_en_o to 0 from the next edge.
- R5: An ack_done_i pulse sampled while hs_mode_i is 1 forces pu_en_o to 0 from the next edge. This pulse marks the end of an acknowledge or not-acknowledge slot.
- R6: After an R4 or R5 disable, the enable returns only after the synchronised SCL has been seen low and then high with scl_drive_low_i at 0. Keeping SCL high the whole time does not bring the enable back.
- R7: A stop_i pulse forces pu_en_o to 0 from the next edge and cancels any pending re-enable. SCL activity then has no effect until the next hs_mode_i rise.
- R8: pu_en_o is 0 whenever scl_drive_low_i is 1.
- R9: With hs_mode_i at 0, rep_start_i, ack_done_i and SCL activity leave pu_en_o at 0.
- R10: hs_mode_i falling forces pu_en_o to 0 from the next edge. If the same edge also carries a strobe, stop_i or a low hs_mode_i wins over a hs_mode_i rise. A hs_mode_i rise wins over rep_start_i or ack_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level as seen on the bus (asynchronous) |
| scl_drive_low_i | input | 1 | Master is pulling SCL low |
| hs_mode_i | input | 1 | High-speed mode active (rises after the master-code not-acknowledge) |
| rep_start_i | input | 1 | One-cycle strobe: repeated START issued |
| ack_done_i | input | 1 | One-cycle strobe: acknowledge or not-acknowledge slot finished |
| stop_i | input | 1 | One-cycle strobe: STOP issued |
| pu_en_o | output | 1 | Current-source pull-up enable |

## Verification
The hardest case to reach is the stretched re-enable. A strobe must land while the pull-up is on. SCL must then stay high for a while without the enable coming back. After that SCL goes low, possibly with a one-cycle high glitch, and is finally released. The glitch has to reach the synchroniser at exactly the moment the wait-for-high state is live. Directed sequences force each of these orderings. They include a strobe while SCL sits high, a glitch right after the low phase, and a strobe on the same edge as a mode rise. A long random phase with SCL, the master drive and the strobes biased toward bus-like patterns then compares every cycle against a bench model.

// File: rtl/scl_pu_pkg.sv
package scl_pu_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ARM_IDLE      = 2'd0,
    ARM_WAIT_LOW  = 2'd1,
    ARM_WAIT_HIGH = 2'd2
  } arm_e;
endpackage

// File: rtl/scl_pu_sync.sv
module scl_pu_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= RST_VAL;
        else         pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/scl_pu_mode_edge.sv
module scl_pu_mode_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_mode_i,
  output logic hs_rise_o
);
  // reset high: a flag already set at reset release does not arm (R1)
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= hs_mode_i;

  assign hs_rise_o = hs_mode_i & ~prev_q;
endmodule

// File: rtl/scl_pu_core.sv
module scl_pu_core
  import scl_pu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic drive_low_i,
  input  logic hs_mode_i,
  input  logic hs_rise_i,
  input  logic rep_start_i,
  input  logic ack_done_i,
  input  logic stop_i,
  output logic active_o
);
  arm_e arm_q, arm_d;
  logic active_q, active_d;

  always_comb begin
    arm_d    = arm_q;
    active_d = active_q;
    if (!hs_mode_i || stop_i) begin
      arm_d    = ARM_IDLE;
      active_d = 1'b0;
    end else if (hs_rise_i) begin
      arm_d    = ARM_WAIT_HIGH;
      active_d = 1'b0;
    end else if (rep_start_i || ack_done_i) begin
      arm_d    = ARM_WAIT_LOW;
      active_d = 1'b0;
    end else begin
      unique case (arm_q)
        ARM_WAIT_LOW:  if (!scl_s_i) arm_d = ARM_WAIT_HIGH;
        ARM_WAIT_HIGH: if (scl_s_i && !drive_low_i) begin
          arm_d    = ARM_IDLE;
          active_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      arm_q    <= ARM_IDLE;
      active_q <= 1'b0;
    end else begin
      arm_q    <= arm_d;
      active_q <= active_d;
    end

  assign active_o = active_q;

  // R3
  sync_high_before_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(scl_s_i) && !$past(drive_low_i));
  // R4
  rep_start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_i && rep_start_i) |=> !active_q);
  // R5
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_i && ack_done_i) |=> !active_q);
  // R6
  no_reen_from_wait_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q == ARM_WAIT_LOW) |=> !active_q);
  // R7
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !active_q && arm_q == ARM_IDLE);
  // R10
  mode_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_mode_i |=> !active_q);
endmodule

// File: rtl/scl_cs_pullup_ctrl.sv
module scl_cs_pullup_ctrl
  import scl_pu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic scl_drive_low_i,
  input  logic hs_mode_i,
  input  logic rep_start_i,
  input  logic ack_done_i,
  input  logic stop_i,
  output logic pu_en_o
);
  logic scl_s, hs_rise, active;

  scl_pu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );

  scl_pu_mode_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_mode_i(hs_mode_i), .hs_rise_o(hs_rise)
  );

  scl_pu_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .drive_low_i(scl_drive_low_i),
    .hs_mode_i(hs_mode_i), .hs_rise_i(hs_rise), .rep_start_i(rep_start_i),
    .ack_done_i(ack_done_i), .stop_i(stop_i), .active_o(active)
  );

  // never fight the master's own pull-down
  assign pu_en_o = active & ~scl_drive_low_i;

  // R8
  no_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_drive_low_i |-> !pu_en_o);
  // R9
  fs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_mode_i && !$past(hs_mode_i)) |-> !pu_en_o);
endmodule

// File: tb/scl_cs_pullup_ctrl_test.sv
`timescale 1ns/1ps
module scl_cs_pullup_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, drv = 1'b0, hs = 1'b0, rs = 1'b0, ak = 1'b0, sp = 1'b0;
  logic pu_en;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  scl_cs_pullup_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .scl_drive_low_i(drv),
    .hs_mode_i(hs), .rep_start_i(rs), .ack_done_i(ak), .stop_i(sp), .pu_en_o(pu_en)
  );

  // reference model built from the requirements; arm: 0 idle, 1 wait low, 2 wait high
  logic m_s1, m_s2, m_prev, m_act;
  logic [1:0] m_arm;

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_prev = 1; m_act = 0; m_arm = 0;
  endtask

  task automatic model_step();
    logic rise;
    rise = hs & ~m_prev;
    if (!hs || sp) begin m_act = 0; m_arm = 0; end
    else if (rise) begin m_act = 0; m_arm = 2; end
    else if (rs || ak) begin m_act = 0; m_arm = 1; end
    else if (m_arm == 1 && !m_s2) m_arm = 2;
    else if (m_arm == 2 && m_s2 && !drv) begin m_act = 1; m_arm = 0; end
    m_prev = hs;
    m_s2 = m_s1;
    m_s1 = scl;
  endtask

  function automatic logic exp_en();
    return m_act & ~drv;
  endfunction

  task automatic chk(input logic exp, input string tag);
    n_run++;
    if (pu_en !== exp) begin
      n_fail++;
      $display("FAIL %s: pu_en_o=%0b expected %0b at %0t", tag, pu_en, exp, $time);
    end
  endtask

  // one clock; model advances with the DUT, compare away from the edge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(exp_en(), tag);
  endtask

  task automatic cycn(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pulse(ref logic s, input string tag);
    s = 1; cyc(tag); s = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: timeout");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    hs = 1; scl = 1;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 in reset");
    rst_n = 1;
    cycn(6, "R1 no arm with flag held through reset");
    chk(1'b0, "R1 after release");

    // R2 entry
    hs = 0; cyc("R10");
    hs = 1; cyc("R2");
    chk(1'b0, "R2 one edge after rise");
    cyc("R2");
    chk(1'b1, "R2 enabled second edge");

    // R8
    drv = 1; #1; chk(1'b0, "R8 master drives low");
    cyc("R8"); drv = 0; cyc("R8");
    chk(1'b1, "R8 restored");

    // R4 with SCL held high: no return (R6)
    pulse(rs, "R4");
    chk(1'b0, "R4 dropped after Sr");
    cycn(8, "R6 scl stays high");
    chk(1'b0, "R6 no re-enable without low");
    scl = 0; cycn(3, "R6 low"); scl = 1;
    cyc("R3"); cyc("R3");
    chk(1'b0, "R3 two edges after rise");
    cyc("R3");
    chk(1'b1, "R6 re-enabled after low then high");

    // R5 with stretch and a one-cycle high glitch
    pulse(ak, "R5");
    chk(1'b0, "R5 dropped after ack slot");
    scl = 0; cycn(4, "R5 stretch");
    scl = 1; cyc("R3 glitch"); scl = 0; cycn(5, "R3 glitch");
    scl = 1; cycn(3, "R6");
    chk(1'b1, "R6 after stretch");

    // R7
    pulse(sp, "R7");
    chk(1'b0, "R7 off after stop");
    scl = 0; cycn(3, "R7"); scl = 1; cycn(5, "R7");
    chk(1'b0, "R7 stays off");

    // R9
    hs = 0; cyc("R9");
    rs = 1; ak = 1; cyc("R9"); rs = 0; ak = 0;
    scl = 0; cycn(3, "R9"); scl = 1; cycn(4, "R9");
    chk(1'b0, "R9 ignored in F/S mode");

    // R10 priority: rise with same-edge strobe; then fall
    hs = 1; rs = 1; cyc("R10"); rs = 0;
    cycn(2, "R10");
    chk(1'b1, "R10 rise beats Sr");
    hs = 0; cyc("R10");
    chk(1'b0, "R10 off after mode fall");

    // random, bus-like bias
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) hs = ~hs;
      else if (r < 30) scl = ~scl;
      drv = ($urandom % 100) < 20;
      rs  = ($urandom % 100) < 3;
      ak  = ($urandom % 100) < 4;
      sp  = ($urandom % 100) < 1;
      cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial void'($urandom(32'h5c1));
endmodule